// File: doc/BRIEF.md
# Way-Lockable Set-Associative Cache

This block is a small write-back cache that sits between a processor-side load/store port and a memory-side port that moves whole lines. Lookups that hit are answered one cycle after acceptance. A miss stalls the processor port while the block optionally writes a dirty victim back to memory and then fetches the missing line over a valid/ready handshake. The number of sets, the number of ways and the number of words per line are parameters. One way gives a direct-mapped cache and one set gives a fully associative one. Total capacity is sets times ways lines.

Any single way can be pinned. A lock command names a way and a base line address. The block then loads that way in every set, set 0 first and the last set last, from consecutive line addresses. It sets the way's lock bit only once the last set has been loaded. A locked way still serves hits and stores. The replacement logic never picks it as a victim. At most half of the ways may be locked at a time, and a lock command beyond that limit is refused. Unlocking clears the bit at once and leaves the way's contents in place.

Misses fill an invalid unlocked way first. When every unlocked way of the set is valid, the victim is picked pseudo-randomly among the unlocked ways by a free-running shift register.

Top module: `lockable_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `lock_mask`, `lock_err`, `resp_valid` and `mem_valid` are all 0.
- R2: Every read returns the most recent value stored at that word address. A hit (read or write) raises `resp_valid` in the cycle after the request is accepted. During a miss `req_ready` stays 0 until the line is installed.
- R3: A request that hits makes no memory-side transfer.
- R4: While the indexed set still has an invalid unlocked way, a miss fills that way and evicts no valid line. After reset, WAYS distinct lines that map to one set therefore all stay resident.
- R5: A dirty victim is written to memory (`mem_write`=1) before the refill read, and the written line carries the stored data. A clean victim is never written to memory.
- R6: A lock command (`lock_valid`=1, `lock_on`=1) for way w fills way w of set s from line address `(lock_base - lock_base mod SETS) + s`, for s = 0, 1, … in increasing order. The lines are loaded clean. `lock_mask[w]` becomes 1 only after the last set has been loaded.
- R7: If the requested way is unlocked and WAYS/2 ways are already locked, the command is refused. `lock_err` is 1 for the one cycle after acceptance, `lock_mask` is unchanged and no memory transfer occurs.
- R8: A locked way is never chosen as a victim. Reads and writes that hit a locked line are served normally, without memory traffic.
- R9: An unlock command (`lock_valid`=1, `lock_on`=0) clears `lock_mask[w]` in the next cycle. The way's lines stay valid and continue to hit.
- R10: While a preload runs, `req_ready` is 0, starting from the cycle after the lock command is accepted.
- R11: Once `mem_valid` is raised, it stays 1 with `mem_addr` and `mem_write` held stable until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| resp_valid | output | 1 | One-cycle response strobe (loads and stores) |
| resp_rdata | output | DW | Load data |
| lock_valid | input | 1 | Lock command present (taken in idle when no request) |
| lock_on | input | 1 | 1 = preload and lock, 0 = unlock |
| lock_way | input | WIW | Target way |
| lock_base | input | LAW | Base line address for preload |
| lock_mask | output | WAYS | Current lock bit of each way |
| lock_err | output | 1 | Lock command refused (one cycle) |
| mem_valid | output | 1 | Memory transfer request |
| mem_ready | input | 1 | Memory transfer completes this cycle |
| mem_write | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | LAW | Line address |
| mem_wline | output | DW*LINE_WORDS | Line written to memory |
| mem_rline | input | DW*LINE_WORDS | Line returned by memory, valid with mem_ready |

## Verification
The bench first streams distinct lines into one set and reads them again. It then overfills that set with clean lines, and then repeats misses over a dirty line until that line is evicted. Together these separate the invalid-first fill from replacement, and a clean eviction from a write-back. Next it preloads a way, hammers every set with far more lines than the set holds, and re-reads the preloaded lines. A resident line costs no memory read, so this shows whether the lock keeps the way out of replacement. Finally it issues a second lock, a refused third one, a store into a locked line and an unlock. These tell the lock limit apart from a plain refill, and an unlock apart from a flush.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WB    = 3'd1,
        ST_FILL  = 3'd2,
        ST_PWB   = 3'd3,
        ST_PFILL = 3'd4
    } lc_state_e;
endpackage

// File: rtl/lc_lfsr.sv
`timescale 1ns/1ps
module lc_lfsr #(
    parameter logic [7:0] SEED = 8'h5A
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [7:0] rnd
);
    logic [7:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign rnd = lfsr_q;
endmodule

// File: rtl/lc_victim.sv
`timescale 1ns/1ps
module lc_victim #(
    parameter int WAYS = 4,
    parameter int WIW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0] valid_row,
    input  logic [WAYS-1:0] lock,
    input  logic [7:0]      rnd,
    output logic [WIW-1:0]  way
);
    always_comb begin
        logic found;
        int   start;
        int   cand;
        found = 1'b0;
        way   = '0;
        // empty unlocked ways are used before anything is evicted
        for (int i = 0; i < WAYS; i++) begin
            if (!found && !valid_row[i] && !lock[i]) begin
                way   = WIW'(i);
                found = 1'b1;
            end
        end
        // random start, then first unlocked way upward with wrap
        start = int'(rnd) % WAYS;
        for (int j = 0; j < WAYS; j++) begin
            cand = (start + j) % WAYS;
            if (!found && !lock[cand]) begin
                way   = WIW'(cand);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lockable_cache.sv
`timescale 1ns/1ps
module lockable_cache #(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int SETS       = 4,
    parameter int WAYS       = 4,
    parameter int LINE_WORDS = 4,
    localparam int OFFB = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 0,
    localparam int OW   = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
    localparam int LAW  = AW - OFFB,
    localparam int LW   = DW * LINE_WORDS,
    localparam int IW   = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WIW  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int MAXL = WAYS / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            resp_valid,
    output logic [DW-1:0]   resp_rdata,
    input  logic            lock_valid,
    input  logic            lock_on,
    input  logic [WIW-1:0]  lock_way,
    input  logic [LAW-1:0]  lock_base,
    output logic [WAYS-1:0] lock_mask,
    output logic            lock_err,
    output logic            mem_valid,
    input  logic            mem_ready,
    output logic            mem_write,
    output logic [LAW-1:0]  mem_addr,
    output logic [LW-1:0]   mem_wline,
    input  logic [LW-1:0]   mem_rline
);
    import lc_pkg::*;

    typedef logic [LINE_WORDS-1:0][DW-1:0] line_t;

    typedef struct packed {
        lc_state_e                                     state;
        logic [SETS-1:0][WAYS-1:0][LAW-1:0]            tag;
        logic [SETS-1:0][WAYS-1:0][LINE_WORDS-1:0][DW-1:0] data;
        logic [SETS-1:0][WAYS-1:0]                     vld;
        logic [SETS-1:0][WAYS-1:0]                     drt;
        logic [WAYS-1:0]                               lock;
        logic                                          wr;
        logic [AW-1:0]                                 addr;
        logic [DW-1:0]                                 wdata;
        logic [WIW-1:0]                                vic;
        logic [IW-1:0]                                 pset;
        logic [WIW-1:0]                                pway;
        logic [LAW-1:0]                                pbase;
        logic                                          rv;
        logic [DW-1:0]                                 rdata;
        logic                                          lerr;
    } st_t;

    st_t s_d, s_q;

    function automatic logic [LAW-1:0] line_of(input logic [AW-1:0] a);
        return LAW'(a >> OFFB);
    endfunction
    function automatic logic [IW-1:0] set_of(input logic [LAW-1:0] la);
        return IW'(la % LAW'(SETS));
    endfunction
    function automatic logic [OW-1:0] off_of(input logic [AW-1:0] a);
        return OW'(a % AW'(LINE_WORDS));
    endfunction
    function automatic int locked_count(input logic [WAYS-1:0] m);
        int c;
        c = 0;
        for (int i = 0; i < WAYS; i++) c += int'(m[i]);
        return c;
    endfunction

    logic [LAW-1:0] req_line;
    logic [IW-1:0]  req_set;
    logic [OW-1:0]  req_off;
    logic [IW-1:0]  cur_set;
    logic [OW-1:0]  cur_off;
    logic           hit;
    logic [WIW-1:0] hit_way;
    logic [WIW-1:0] pick_way;
    logic [7:0]     rnd;

    assign req_line = line_of(req_addr);
    assign req_set  = set_of(req_line);
    assign req_off  = off_of(req_addr);
    assign cur_set  = set_of(line_of(s_q.addr));
    assign cur_off  = off_of(s_q.addr);

    lc_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .rnd(rnd));

    lc_victim #(.WAYS(WAYS), .WIW(WIW)) u_victim (
        .valid_row(s_q.vld[req_set]),
        .lock     (s_q.lock),
        .rnd      (rnd),
        .way      (pick_way)
    );

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (s_q.vld[req_set][i] && s_q.tag[req_set][i] == req_line) begin
                hit     = 1'b1;
                hit_way = WIW'(i);
            end
        end
    end

    always_comb begin
        line_t ln;
        s_d       = s_q;
        s_d.rv    = 1'b0;
        s_d.lerr  = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;
        mem_wline = '0;
        ln        = '0;
        case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.wr    = req_write;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    if (hit) begin
                        s_d.rv = 1'b1;
                        if (req_write) begin
                            s_d.data[req_set][hit_way][req_off] = req_wdata;
                            s_d.drt[req_set][hit_way]           = 1'b1;
                        end else begin
                            s_d.rdata = s_q.data[req_set][hit_way][req_off];
                        end
                    end else begin
                        s_d.vic   = pick_way;
                        s_d.state = (s_q.vld[req_set][pick_way] && s_q.drt[req_set][pick_way])
                                    ? ST_WB : ST_FILL;
                    end
                end else if (lock_valid) begin
                    if (!lock_on) begin
                        s_d.lock[lock_way] = 1'b0;
                    end else if (!s_q.lock[lock_way] && locked_count(s_q.lock) >= MAXL) begin
                        s_d.lerr = 1'b1;
                    end else begin
                        s_d.pway  = lock_way;
                        s_d.pset  = '0;
                        s_d.pbase = lock_base - LAW'(lock_base % LAW'(SETS));
                        s_d.state = (s_q.vld[0][lock_way] && s_q.drt[0][lock_way])
                                    ? ST_PWB : ST_PFILL;
                    end
                end
            end
            ST_WB: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = s_q.tag[cur_set][s_q.vic];
                mem_wline = s_q.data[cur_set][s_q.vic];
                if (mem_ready) s_d.state = ST_FILL;
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = line_of(s_q.addr);
                if (mem_ready) begin
                    ln = mem_rline;
                    if (s_q.wr) ln[cur_off] = s_q.wdata;
                    else        s_d.rdata   = ln[cur_off];
                    s_d.data[cur_set][s_q.vic] = ln;
                    s_d.tag[cur_set][s_q.vic]  = line_of(s_q.addr);
                    s_d.vld[cur_set][s_q.vic]  = 1'b1;
                    s_d.drt[cur_set][s_q.vic]  = s_q.wr;
                    s_d.rv    = 1'b1;
                    s_d.state = ST_IDLE;
                end
            end
            ST_PWB: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = s_q.tag[s_q.pset][s_q.pway];
                mem_wline = s_q.data[s_q.pset][s_q.pway];
                if (mem_ready) s_d.state = ST_PFILL;
            end
            ST_PFILL: begin
                mem_valid = 1'b1;
                mem_addr  = s_q.pbase + LAW'(s_q.pset);
                if (mem_ready) begin
                    s_d.data[s_q.pset][s_q.pway] = mem_rline;
                    s_d.tag[s_q.pset][s_q.pway]  = s_q.pbase + LAW'(s_q.pset);
                    s_d.vld[s_q.pset][s_q.pway]  = 1'b1;
                    s_d.drt[s_q.pset][s_q.pway]  = 1'b0;
                    if (s_q.pset == IW'(SETS - 1)) begin
                        s_d.lock[s_q.pway] = 1'b1;
                        s_d.state          = ST_IDLE;
                    end else begin
                        s_d.pset  = s_q.pset + 1'b1;
                        s_d.state = (s_q.vld[s_q.pset + 1'b1][s_q.pway] &&
                                     s_q.drt[s_q.pset + 1'b1][s_q.pway]) ? ST_PWB : ST_PFILL;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready  = (s_q.state == ST_IDLE);
    assign resp_valid = s_q.rv;
    assign resp_rdata = s_q.rdata;
    assign lock_mask  = s_q.lock;
    assign lock_err   = s_q.lerr;

    // R7: never more than half the ways pinned
    p_lock_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.lock) <= MAXL);

    // R7: a refused command leaves the mask as it was
    p_refuse_keeps_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lerr |-> (s_q.lock == $past(s_q.lock)));

    // R8: a refill never lands in a pinned way
    p_victim_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_FILL && mem_ready) |-> !s_q.lock[s_q.vic]);

    // R6: a lock bit only appears right after the last preload read completes
    p_lock_after_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(s_q.lock) > $countones($past(s_q.lock)))
            |-> ($past(s_q.state) == ST_PFILL && $past(mem_ready)));

    // R11: memory request held steady until accepted
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));
endmodule

// File: tb/tb_lockable_cache.sv
`timescale 1ns/1ps
module tb_lockable_cache;
    localparam int AW = 16, DW = 32, SETS = 4, WAYS = 4, LINE_WORDS = 4;
    localparam int LAW = AW - 2, LW = DW * LINE_WORDS, WIW = 2;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, resp_valid, lock_err, mem_valid, mem_write;
    logic [DW-1:0] resp_rdata;
    logic lock_valid = 0, lock_on = 0;
    logic [WIW-1:0] lock_way = '0;
    logic [LAW-1:0] lock_base = '0, mem_addr;
    logic [WAYS-1:0] lock_mask;
    logic mem_ready = 0;
    logic [LW-1:0] mem_wline, mem_rline = '0;

    lockable_cache #(.AW(AW), .DW(DW), .SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .lock_valid(lock_valid),
        .lock_on(lock_on), .lock_way(lock_way), .lock_base(lock_base),
        .lock_mask(lock_mask), .lock_err(lock_err), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wline(mem_wline), .mem_rline(mem_rline));

    always #10 clk = ~clk;

    int total = 0, bad = 0;
    int rd_cnt = 0, wr_cnt = 0, order_bad = 0, mcnt = 0;
    bit last_wr = 0;
    int rd_log[$];
    logic [LW-1:0] bmem[int];
    logic [DW-1:0] refw[int];

    typedef struct { bit rd; logic [DW-1:0] v; } exp_t;
    exp_t exp_q[$];

    function automatic logic [DW-1:0] winit(int la, int w);
        return 32'hA000_0000 + la * 16 + w;
    endfunction
    function automatic logic [LW-1:0] get_line(int la);
        logic [LW-1:0] l;
        if (bmem.exists(la)) return bmem[la];
        for (int w = 0; w < LINE_WORDS; w++) l[w*DW +: DW] = winit(la, w);
        return l;
    endfunction
    function automatic logic [DW-1:0] ref_rd(int a);
        if (refw.exists(a)) return refw[a];
        return winit(a / LINE_WORDS, a % LINE_WORDS);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model: two-cycle latency, inputs changed at negedge
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 0;
            mcnt = 0;
        end else if (mem_valid) begin
            mcnt++;
            if (mcnt == 2) begin
                mem_ready = 1;
                if (mem_write) begin
                    bmem[int'(mem_addr)] = mem_wline;
                    wr_cnt++;
                    if (last_wr) order_bad++;
                    last_wr = 1;
                end else begin
                    mem_rline = get_line(int'(mem_addr));
                    rd_cnt++;
                    rd_log.push_back(int'(mem_addr));
                    last_wr = 0;
                end
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R2", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.rd) check(resp_rdata == e.v, "R2", "read data", resp_rdata, e.v);
            end
        end
    end

    task automatic do_req(bit wr, int a, logic [DW-1:0] d, bit want_hit);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d;
        e.rd = !wr;
        e.v  = wr ? '0 : ref_rd(a);
        if (wr) refw[a] = d;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 0;
        if (want_hit) check(resp_valid === 1'b1, "R2", "hit latency", resp_valid, 1);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic lock_cmd(bit on, int w, int base, output bit err, output bit rdy);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        lock_valid = 1; lock_on = on; lock_way = WIW'(w); lock_base = LAW'(base);
        @(negedge clk);
        lock_valid = 0;
        err = lock_err;
        rdy = req_ready;
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int r0, w0, base_idx;
        bit err, rdy;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1, "R1", "req_ready", req_ready, 1);
        check(lock_mask == 0, "R1", "lock_mask", lock_mask, 0);
        check(lock_err == 0 && resp_valid == 0 && mem_valid == 0, "R1", "strobes idle",
              {lock_err, resp_valid, mem_valid}, 0);

        // R4: four lines of set 0 all stay resident
        r0 = rd_cnt;
        for (int k = 0; k < WAYS; k++) do_req(0, (4 * k) * LINE_WORDS, 0, 0);
        check(rd_cnt - r0 == WAYS, "R4", "fill reads", rd_cnt - r0, WAYS);
        r0 = rd_cnt;
        for (int k = 0; k < WAYS; k++) do_req(0, (4 * k) * LINE_WORDS + 1, 0, 1);
        check(rd_cnt - r0 == 0, "R3", "hits need no memory (R4 residency)", rd_cnt - r0, 0);

        // R5 clean eviction writes nothing
        do_req(0, 16 * LINE_WORDS, 0, 0);
        check(wr_cnt == 0, "R5", "clean victim not written", wr_cnt, 0);

        // R2 store miss then read hit
        do_req(1, 20 * LINE_WORDS + 1, 32'h1234_5678, 0);
        do_req(0, 20 * LINE_WORDS + 1, 0, 1);

        // R5 dirty eviction: hammer set 0 until line 20 is written back
        for (int k = 0; k < 48; k++) begin
            if (bmem.exists(20)) break;
            do_req(0, (24 + 4 * k) * LINE_WORDS, 0, 0);
        end
        check(bmem.exists(20) && bmem[20][1*DW +: DW] == 32'h1234_5678, "R5",
              "written-back data", bmem.exists(20) ? bmem[20][1*DW +: DW] : 0, 32'h1234_5678);
        check(order_bad == 0, "R5", "write-back followed by refill", order_bad, 0);
        do_req(0, 20 * LINE_WORDS + 1, 0, 0);

        // R6/R10 preload way 0 from base line 101 (aligned to 100)
        base_idx = rd_log.size();
        w0 = wr_cnt;
        lock_cmd(1, 0, 101, err, rdy);
        check(rdy == 0, "R10", "ready low during preload", rdy, 0);
        check(lock_mask == 4'b0001, "R6", "lock bit set", lock_mask, 1);
        check(rd_log.size() - base_idx == SETS, "R6", "preload reads", rd_log.size() - base_idx, SETS);
        for (int s = 0; s < SETS; s++)
            check(rd_log[base_idx + s] == 100 + s, "R6", "preload order", rd_log[base_idx + s], 100 + s);
        r0 = rd_cnt;
        for (int s = 0; s < SETS; s++) do_req(0, (100 + s) * LINE_WORDS + 2, 0, 1);
        check(rd_cnt - r0 == 0, "R6", "preloaded lines hit", rd_cnt - r0, 0);

        // R8 hammer every set, locked lines must survive
        for (int s = 0; s < SETS; s++)
            for (int k = 0; k < 3 * WAYS; k++) do_req(0, (200 + 4 * k + s) * LINE_WORDS, 0, 0);
        r0 = rd_cnt;
        for (int s = 0; s < SETS; s++) do_req(0, (100 + s) * LINE_WORDS + 3, 0, 1);
        check(rd_cnt - r0 == 0, "R8", "locked lines never evicted", rd_cnt - r0, 0);

        // R7 limit
        lock_cmd(1, 1, 300, err, rdy);
        check(lock_mask == 4'b0011 && err == 0, "R7", "second lock accepted", lock_mask, 3);
        r0 = rd_cnt;
        lock_cmd(1, 2, 400, err, rdy);
        check(err == 1, "R7", "lock_err on third lock", err, 1);
        check(lock_mask == 4'b0011 && rd_cnt == r0 && rdy == 1, "R7", "mask kept, no traffic",
              lock_mask, 3);

        // R8 store into locked line is a hit
        r0 = rd_cnt;
        do_req(1, 100 * LINE_WORDS + 2, 32'hCAFE_0001, 1);
        do_req(0, 100 * LINE_WORDS + 2, 0, 1);
        check(rd_cnt - r0 == 0, "R8", "locked store hit", rd_cnt - r0, 0);

        // R9 unlock keeps contents
        lock_cmd(0, 0, 0, err, rdy);
        check(lock_mask == 4'b0010, "R9", "unlock mask", lock_mask, 2);
        r0 = rd_cnt;
        do_req(0, 101 * LINE_WORDS, 0, 1);
        do_req(0, 100 * LINE_WORDS + 2, 0, 1);
        check(rd_cnt - r0 == 0, "R9", "unlocked lines still hit", rd_cnt - r0, 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", "all responses seen", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule